// File: doc/BRIEF.md
# Dual-Mode Host Bus Channel Selector

This block is the host-facing register access front end of a four-channel serial controller. A static strap chooses between two host bus styles. In the strobe style, the host has separate active-low read and write strobes and one active-low select line per channel. In the addressed style, the host has one active-low select, a direction line (the former write strobe) and two channel-number bits. The block brings the host lines into the system clock through synchronizers. It works out which channel or channels a cycle targets and forwards a 3-bit register index and a data byte to a small register file per channel, which stands in for the real serial engine.

Writes can reach every channel at once for bulk initialization. A read returns one byte only when exactly one channel is addressed. When a channel's divisor pair is zero, reading it returns an identification code. Interrupt requests from the channels leave the block either as per-channel outputs with individual drive enables, or as one shared open-drain pull-down, depending on the bus style. The host bus is strobe-timed and has no valid/ready handshake. Back-pressure is expressed only as timing: the host holds address and data steady for the strobe length plus the synchronizer delay.

Top module: `hbus_chan_sel`

## Requirements
- R1: With `mode_sep`=1, each low bit of `cs_n` selects the channel with that index (bit 0 = channel A … bit 3 = channel D). With `cs_n`=4'b1111, a write changes no channel.
- R2: With `mode_sep`=1 and `cs_n`=4'b0000, one write stores the same byte at the same index in all four channels.
- R3: A read with more than one channel selected never raises `rdata_oe`.
- R4: In strobe style, `rdata_oe` rises within 4 clocks of `rd_n` falling while exactly one channel is selected. `rdata` then holds the addressed byte and stays stable while `rdata_oe` is high. `rdata_oe` falls within 4 clocks of `rd_n` rising.
- R5: In strobe style, a write takes effect when `wr_n` returns high, using the index, byte and selects held during the strobe.
- R6: With `mode_sep`=0, a cycle runs while `cs_n[0]` is low. `ch_sel` 0,1,2,3 picks channel A,B,C,D. Only that one channel is affected.
- R7: With `mode_sep`=0, `wr_n` is the direction: 1 means read, 0 means write, committed when `cs_n[0]` rises. `rd_n` and `cs_n[3:1]` have no effect.
- R8: Each channel has eight registers at indexes 0..7. While bit 7 of register 3 is 1, indexes 0 and 1 reach the lower and upper divisor bytes instead of registers 0 and 1.
- R9: With the divisor window open and both divisor bytes 0x00, index 1 reads 0x14 and index 0 reads 0x01.
- R10: With `mode_sep`=1, `irq_ch[i]` follows `irq_req[i]`, and `irq_ch_oe[i]` equals bit 3 of channel i's register 4. That bit is 0 after reset.
- R11: With `mode_sep`=0, every `irq_ch_oe` bit is 0, and `irq_wired_low` is 1 exactly while any `irq_req` bit is 1. With `mode_sep`=1, `irq_wired_low` is 0.
- R12: After reset all registers read 0x00, `rdata_oe` is 0 and no interrupt output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sep | input | 1 | Bus style strap: 1 strobe style, 0 addressed style |
| cs_n | input | 4 | Per-channel selects (strobe style); bit 0 is the single select (addressed style) |
| rd_n | input | 1 | Read strobe, active low (strobe style only) |
| wr_n | input | 1 | Write strobe (strobe style) or direction, 1 = read (addressed style) |
| addr | input | 3 | Register index |
| ch_sel | input | 2 | Channel number (addressed style only) |
| wdata | input | 8 | Write byte from host |
| irq_req | input | 4 | Interrupt requests from the channel engines |
| rdata | output | 8 | Read byte to host |
| rdata_oe | output | 1 | Drive enable for `rdata` |
| irq_ch | output | 4 | Per-channel interrupt level |
| irq_ch_oe | output | 4 | Per-channel interrupt drive enable |
| irq_wired_low | output | 1 | Pull-down enable for the shared open-drain interrupt |

## Verification
The bench targets the all-select broadcast write. A design that decoded only one-hot patterns would update one channel or none. It also runs reads with two or four channels selected, where a design that merged read data would raise `rdata_oe`. It opens the divisor window with both bytes at zero to confirm the identification codes, then writes a nonzero divisor, where a design that kept returning the codes would read wrong. In addressed style it toggles `rd_n` and the upper selects during cycles to catch a decoder that still listens to them. It also checks that interrupt enables follow register 4 in one style and fold into the shared pull-down in the other.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  localparam int REG_LINE_CTL   = 3;
  localparam int WIN_BIT        = 7;
  localparam int REG_MODEM_CTL  = 4;
  localparam int IRQ_DRIVE_BIT  = 3;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int W = 6,
  parameter int STAGES = 2
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '1;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chan_regs.sv
module chan_regs import hbs_pkg::*; #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter logic [DW-1:0] DEV_ID = 8'h14,
  parameter logic [DW-1:0] REV_ID = 8'h01
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_val,
  output logic          irq_drive
);
  localparam int NREG = 2 ** AW;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] div_lo, div_hi;
  logic          win, div_zero;

  assign win       = regs[REG_LINE_CTL][WIN_BIT];
  assign div_zero  = (div_lo == '0) && (div_hi == '0);
  assign irq_drive = regs[REG_MODEM_CTL][IRQ_DRIVE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      div_lo <= '0;
      div_hi <= '0;
    end else if (we) begin
      if (win && waddr == AW'(0))      div_lo <= wdata;
      else if (win && waddr == AW'(1)) div_hi <= wdata;
      else                             regs[waddr] <= wdata;
    end
  end

  always_comb begin
    if (win && raddr == AW'(0))      rd_val = div_zero ? REV_ID : div_lo;
    else if (win && raddr == AW'(1)) rd_val = div_zero ? DEV_ID : div_hi;
    else                             rd_val = regs[raddr];
  end

  p_div_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(div_lo) && $stable(div_hi)));
endmodule

// File: rtl/hbus_chan_sel.sv
module hbus_chan_sel import hbs_pkg::*; #(
  parameter int NCH  = 4,
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int SYNC = 2,
  parameter int CW   = $clog2(NCH),
  parameter logic [DW-1:0] DEV_ID = 8'h14,
  parameter logic [DW-1:0] REV_ID = 8'h01
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_sep,
  input  logic [NCH-1:0] cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  ch_sel,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] irq_req,
  output logic [DW-1:0]  rdata,
  output logic           rdata_oe,
  output logic [NCH-1:0] irq_ch,
  output logic [NCH-1:0] irq_ch_oe,
  output logic           irq_wired_low
);
  localparam int SW = NCH + 2;

  logic [SW-1:0]  raw_bus, syn_bus;
  logic [NCH-1:0] cs_s;
  logic           rd_s, wr_s;

  assign raw_bus = {wr_n, rd_n, cs_n};

  host_sync #(.W(SW), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
  );

  assign cs_s = syn_bus[NCH-1:0];
  assign rd_s = syn_bus[NCH];
  assign wr_s = syn_bus[NCH+1];

  logic           mode_q, wr_s_d, cs0_d, rd_act_d;
  logic           act, rd_act, rd_start, commit;
  logic [NCH-1:0] mask_now, cap_mask, irq_drive;
  logic [AW-1:0]  cap_addr;
  logic [DW-1:0]  cap_data, rd_pick;
  logic           cap_dir, rd_ok, rd_ok_q;
  logic [DW-1:0]  ch_rd [NCH];

  always_comb begin
    mask_now = '0;
    if (mode_q) mask_now = ~cs_s;
    else if (!cs_s[0]) mask_now[ch_sel] = 1'b1;
  end

  assign act      = mode_q ? (!rd_s || !wr_s) : !cs_s[0];
  assign rd_act   = mode_q ? !rd_s : (!cs_s[0] && wr_s);
  assign rd_start = rd_act && !rd_act_d;
  assign commit   = mode_q ? (wr_s && !wr_s_d) : (cs_s[0] && !cs0_d && !cap_dir);
  assign rd_ok    = $onehot(mask_now);

  always_comb begin
    rd_pick = '0;
    for (int i = 0; i < NCH; i++)
      if (mask_now[i]) rd_pick = rd_pick | ch_rd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b1;
      wr_s_d   <= 1'b1;
      cs0_d    <= 1'b1;
      rd_act_d <= 1'b0;
      cap_mask <= '0;
      cap_addr <= '0;
      cap_data <= '0;
      cap_dir  <= 1'b1;
      rd_ok_q  <= 1'b0;
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      mode_q   <= mode_sep;
      wr_s_d   <= wr_s;
      cs0_d    <= cs_s[0];
      rd_act_d <= rd_act;
      if (act) begin
        cap_mask <= mask_now;
        cap_addr <= addr;
        cap_data <= wdata;
        cap_dir  <= wr_s;
      end
      if (rd_start) begin
        rd_ok_q <= rd_ok;
        rdata   <= rd_pick;
      end
      rdata_oe <= rd_act && (rd_start ? rd_ok : rd_ok_q);
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      chan_regs #(.AW(AW), .DW(DW), .DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(commit && cap_mask[c]),
        .waddr(cap_addr), .wdata(cap_data),
        .raddr(addr), .rd_val(ch_rd[c]),
        .irq_drive(irq_drive[c])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ch        <= '0;
      irq_ch_oe     <= '0;
      irq_wired_low <= 1'b0;
    end else begin
      irq_ch        <= irq_req;
      irq_ch_oe     <= mode_q ? irq_drive : '0;
      irq_wired_low <= !mode_q && (|irq_req);
    end
  end

  p_oe_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(rd_act));
  p_rdata_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && $past(rdata_oe)) |-> $stable(rdata));
  p_single_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !mode_q) |-> $onehot0(cap_mask));
  p_commit_not_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !rd_start);
  p_no_chan_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |=> (irq_ch_oe == '0));
  p_wired_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> !irq_wired_low);
endmodule

// File: tb/tb_hbus_chan_sel.sv
module tb_hbus_chan_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sep = 1'b1;
  logic [3:0] cs_n = 4'hF;
  logic       rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [1:0] ch_sel = '0;
  logic [7:0] wdata = '0;
  logic [3:0] irq_req = '0;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [3:0] irq_ch, irq_ch_oe;
  logic       irq_wired_low;

  int total = 0, bad = 0;
  logic [7:0] m_reg [4][8];
  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];

  always #2.5 clk = ~clk;

  hbus_chan_sel dut (
    .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .ch_sel(ch_sel), .wdata(wdata), .irq_req(irq_req),
    .rdata(rdata), .rdata_oe(rdata_oe), .irq_ch(irq_ch), .irq_ch_oe(irq_ch_oe),
    .irq_wired_low(irq_wired_low)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input int c, input int a);
    logic w = m_reg[c][3][7];
    logic z = (m_lo[c] == 8'h00) && (m_hi[c] == 8'h00);
    if (w && a == 0) return z ? 8'h01 : m_lo[c];
    if (w && a == 1) return z ? 8'h14 : m_hi[c];
    return m_reg[c][a];
  endfunction

  task automatic model_wr(input logic [3:0] mask, input int a, input logic [7:0] d);
    for (int c = 0; c < 4; c++) if (mask[c]) begin
      if (m_reg[c][3][7] && a == 0)      m_lo[c] = d;
      else if (m_reg[c][3][7] && a == 1) m_hi[c] = d;
      else                               m_reg[c][a] = d;
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cs_n = 4'hF; rd_n = 1'b1; wr_n = 1'b1; mode_sep = m;
    wait_cyc(4);
  endtask

  task automatic sep_wr(input logic [3:0] csp, input int a, input logic [7:0] d);
    @(negedge clk);
    cs_n = csp; addr = 3'(a); wdata = d;
    wait_cyc(1); wr_n = 1'b0;
    wait_cyc(3); wr_n = 1'b1;
    wait_cyc(4); cs_n = 4'hF;
    wait_cyc(1);
    model_wr(~csp, a, d);
  endtask

  task automatic sep_rd(input logic [3:0] csp, input int a,
                        output logic [7:0] got, output logic oe, output logic oe_after);
    @(negedge clk);
    cs_n = csp; addr = 3'(a);
    wait_cyc(1); rd_n = 1'b0;
    wait_cyc(5); got = rdata; oe = rdata_oe;
    rd_n = 1'b1;
    wait_cyc(4); oe_after = rdata_oe;
    cs_n = 4'hF;
    wait_cyc(1);
  endtask

  task automatic one_wr(input int c, input int a, input logic [7:0] d, input logic [2:0] junk);
    @(negedge clk);
    ch_sel = 2'(c); addr = 3'(a); wdata = d; wr_n = 1'b0;
    cs_n = {junk, 1'b1}; rd_n = junk[0];
    wait_cyc(1); cs_n[0] = 1'b0;
    wait_cyc(2); rd_n = ~rd_n; cs_n[3:1] = ~junk;
    wait_cyc(2); cs_n[0] = 1'b1;
    wait_cyc(4); wr_n = 1'b1; rd_n = 1'b1; cs_n = 4'hF;
    wait_cyc(1);
    model_wr(4'b0001 << c, a, d);
  endtask

  task automatic one_rd(input int c, input int a, input logic [2:0] junk,
                        output logic [7:0] got, output logic oe);
    @(negedge clk);
    ch_sel = 2'(c); addr = 3'(a); wr_n = 1'b1;
    cs_n = {junk, 1'b1}; rd_n = junk[1];
    wait_cyc(1); cs_n[0] = 1'b0;
    wait_cyc(5); got = rdata; oe = rdata_oe;
    cs_n[0] = 1'b1;
    wait_cyc(4); rd_n = 1'b1; cs_n = 4'hF;
    wait_cyc(1);
  endtask

  initial begin
    wait_cyc(200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic oe, oe2;
    void'($urandom(32'd1357));
    for (int c = 0; c < 4; c++) begin
      m_lo[c] = 0; m_hi[c] = 0;
      for (int a = 0; a < 8; a++) m_reg[c][a] = 0;
    end
    wait_cyc(3); rst_n = 1'b1; wait_cyc(3);

    // R12 reset state
    chk(rdata_oe == 0 && irq_ch_oe == 0 && irq_wired_low == 0, "R12 idle outputs",
        {rdata_oe, irq_ch_oe, irq_wired_low}, 0);
    for (int c = 0; c < 4; c++) begin
      sep_rd(~(4'b0001 << c), 5, got, oe, oe2);
      chk(oe && got == 8'h00, "R12 reg reset", got, 0);
    end

    // R9 / R8 identification and divisor window
    sep_wr(4'b1110, 3, 8'h80);
    sep_rd(4'b1110, 1, got, oe, oe2);
    chk(got == 8'h14, "R9 device code", got, 8'h14);
    sep_rd(4'b1110, 0, got, oe, oe2);
    chk(got == 8'h01, "R9 revision code", got, 8'h01);
    sep_wr(4'b1110, 0, 8'h05);
    sep_rd(4'b1110, 0, got, oe, oe2);
    chk(got == 8'h05, "R8 lower divisor", got, 8'h05);
    sep_rd(4'b1110, 1, got, oe, oe2);
    chk(got == 8'h00, "R8 upper divisor", got, 8'h00);
    sep_wr(4'b1110, 3, 8'h00);
    sep_rd(4'b1110, 0, got, oe, oe2);
    chk(got == exp_rd(0, 0), "R8 window closed", got, exp_rd(0, 0));

    // R2 broadcast
    sep_wr(4'b0000, 2, 8'hA5);
    for (int c = 0; c < 4; c++) begin
      sep_rd(~(4'b0001 << c), 2, got, oe, oe2);
      chk(got == 8'hA5, "R2 broadcast", got, 8'hA5);
    end

    // R1 deselected write, one-hot decode
    sep_wr(4'b1111, 2, 8'h3C);
    for (int c = 0; c < 4; c++) begin
      sep_rd(~(4'b0001 << c), 2, got, oe, oe2);
      chk(got == exp_rd(c, 2), "R1 none selected", got, exp_rd(c, 2));
    end
    sep_wr(4'b1011, 6, 8'h77);
    sep_rd(4'b1011, 6, got, oe, oe2);
    chk(got == 8'h77, "R1 channel C", got, 8'h77);
    sep_rd(4'b0111, 6, got, oe, oe2);
    chk(got == exp_rd(3, 6), "R1 channel D untouched", got, exp_rd(3, 6));

    // R3 multi-select reads, R4 timing
    sep_rd(4'b1100, 2, got, oe, oe2);
    chk(oe == 0, "R3 two selected", oe, 0);
    sep_rd(4'b0000, 2, got, oe, oe2);
    chk(oe == 0, "R3 all selected", oe, 0);
    sep_rd(4'b1101, 2, got, oe, oe2);
    chk(oe == 1 && oe2 == 0, "R4 oe window", {oe, oe2}, 2'b10);

    // R5 commit on strobe release
    @(negedge clk); cs_n = 4'b1110; addr = 3'd7; wdata = 8'h5A;
    wait_cyc(1); wr_n = 1'b0; wait_cyc(1); wdata = 8'h5A; wr_n = 1'b1;
    wait_cyc(4); cs_n = 4'hF; wait_cyc(1); model_wr(4'b0001, 7, 8'h5A);
    sep_rd(4'b1110, 7, got, oe, oe2);
    chk(got == 8'h5A, "R5 short strobe commit", got, 8'h5A);

    // R6 / R7 addressed style
    set_mode(1'b0);
    for (int c = 0; c < 4; c++) begin
      one_wr(c, 5, 8'h10 + 8'(c), 3'b010);
      one_rd(c, 5, 3'b101, got, oe);
      chk(oe && got == 8'h10 + 8'(c), "R6 addressed decode", got, 8'h10 + c);
    end
    one_wr(1, 6, 8'hE1, 3'b000);
    for (int c = 0; c < 4; c++) begin
      one_rd(c, 6, 3'b000, got, oe);
      chk(got == exp_rd(c, 6), "R7 ignored lines", got, exp_rd(c, 6));
    end
    @(negedge clk); rd_n = 1'b0; cs_n = 4'b0001; wait_cyc(6);
    chk(rdata_oe == 0, "R7 rd_n ignored", rdata_oe, 0);
    rd_n = 1'b1; cs_n = 4'hF; wait_cyc(2);

    // R11 merged interrupt
    irq_req = 4'b0100; wait_cyc(3);
    chk(irq_wired_low == 1 && irq_ch_oe == 0, "R11 merged active",
        {irq_wired_low, irq_ch_oe}, 5'b10000);
    irq_req = 4'b0000; wait_cyc(3);
    chk(irq_wired_low == 0, "R11 merged idle", irq_wired_low, 0);

    // R10 per-channel interrupts
    set_mode(1'b1);
    sep_wr(4'b1101, 4, 8'h08);
    sep_wr(4'b1110, 4, 8'h00);
    sep_wr(4'b1011, 4, 8'h00);
    sep_wr(4'b0111, 4, 8'h00);
    irq_req = 4'b1010; wait_cyc(3);
    chk(irq_ch_oe == 4'b0010, "R10 drive enable", irq_ch_oe, 4'b0010);
    chk(irq_ch == 4'b1010 && irq_wired_low == 0, "R10 levels", irq_ch, 4'b1010);
    irq_req = 4'b0000;

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic m = 1'($urandom % 2);
      logic w = 1'($urandom % 2);
      int c = int'($urandom % 4);
      int a = int'($urandom % 8);
      logic [7:0] d = 8'($urandom);
      logic [2:0] j = 3'($urandom);
      if (m != mode_sep) set_mode(m);
      if (m) begin
        logic [3:0] p = ($urandom % 6 == 0) ? 4'b0000 : ~(4'b0001 << c);
        if (w) sep_wr(p, a, d);
        else begin
          sep_rd(p, a, got, oe, oe2);
          if (p == 4'b0000) chk(oe == 0, "R3 random multi", oe, 0);
          else chk(oe && got == exp_rd(c, a), "R1 random read", got, exp_rd(c, a));
        end
      end else begin
        if (w) one_wr(c, a, d, j);
        else begin
          one_rd(c, a, j, got, oe);
          chk(oe && got == exp_rd(c, a), "R6 random read", got, exp_rd(c, a));
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule